// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

A processor-side peripheral that links an 8-bit data bus to three 8-bit parallel ports, named A, B and C. The processor reaches the block with an active-low select, separate active-low read and write strobes and a two-bit address. Writes are sampled on the rising clock edge. Reads are driven without a clock from the stored state and the pins. The data bus is modelled as a separate input, output and output-enable, so the chip level can build the three-state pad.

Port C is split into two nibbles. The upper nibble is grouped with port A and the lower nibble with port B. A control word sets each port or nibble to input or output in plain input/output mode. A control write with bit 7 clear is a single-bit set/clear command for port C. Port A latches its input pins on every clock while it is an input. Port B and port C inputs read the live pins. Each pin group has its own output-data bus and per-bit output-enable bus.

Top module: `ppi_top`

## Requirements
- R1: After reset the control word reads back 9Bh. Every output-enable is 0 and every output latch is 0.
- R2: The address selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control word. A read is cs_n=0, rd_n=0, wr_n=1. A write is cs_n=0, wr_n=0, rd_n=1, and it takes effect at the next rising clock edge.
- R3: When cs_n=1, or when rd_n=1 and wr_n=1, the bus is released (d_oe=0). No register changes in that case.
- R4: When rd_n and wr_n are both 0, nothing happens. d_oe stays 0 and no latch or control bit changes.
- R5: A read of the control word always returns bit 7 as 1, with bits 6..0 as last stored by a mode write.
- R6: A mode write (data bit 7 = 1) sets the directions, where 1 means input. Bit 4 controls port A, bit 3 controls port C[7:4], bit 1 controls port B and bit 0 controls port C[3:0]. Each output-enable bit of a group is 1 exactly when that group is an output.
- R7: A mode write clears the output latches of A, B and C to 0.
- R8: A control write with bit 7 = 0 sets port C bit number data[3:1] to data[0]. It leaves the other port C bits and the stored control word unchanged.
- R9: A read of a port, or a port C nibble, configured as output returns its output latch.
- R10: A read of port A in input mode returns the pins captured at the last clock edge. Port B and input nibbles of port C return the current pins.
- R11: The output-data bus of each port always carries its output latch, including the results of data writes and set/clear commands.
- R12: Nonzero values in control bits 6, 5 and 2 are stored and read back, but they do not change port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target select |
| d_in | input | 8 | Write data from the processor |
| d_out | output | 8 | Read data to the processor |
| d_oe | output | 1 | Drive enable for the data bus |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output data |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output data |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C output data |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
Directed sequences come first. An all-output mode with pattern writes tells latch readback apart from pin readback. Set/clear commands on the top and bottom bit indices show that the command reaches only the chosen bit and not the control word. Mixed-nibble modes show whether the two halves of port C follow separate groups. Conflicting strobes and deselected writes show that dropped accesses really change nothing. Random traffic then mixes every strobe combination, random control words and pins that change each cycle, so a delayed port A capture and a live port B or C read can be told apart.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int AW = 2;
  localparam int NSEL = 1 << AW;
  localparam int BIT_IW = $clog2(DW);

  localparam logic [DW-1:0] CTL_RESET = 8'h9B;
  localparam int MODE_FLAG = 7;
  localparam int DIR_A  = 4;
  localparam int DIR_CU = 3;
  localparam int DIR_B  = 1;
  localparam int DIR_CL = 0;

  typedef enum logic [AW-1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/ppi_rst_sync.sv
module ppi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
  import ppi_pkg::*;
(
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          rd_act,
  output logic          wr_act,
  output logic [NSEL-1:0] sel
);
  always_comb begin
    rd_act = !cs_n && !rd_n &&  wr_n;
    wr_act = !cs_n &&  rd_n && !wr_n;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = (addr == AW'(g));
  end
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] ctrl_q,
  output dir_t          dir,
  output logic          mode_clr,
  output logic          bsr_en,
  output logic [DW-1:0] bsr_mask,
  output logic          bsr_val
);
  logic          ctrl_en;
  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_en  = wr_ctl && din[MODE_FLAG];
    ctrl_d   = din;
    mode_clr = ctrl_en;
    bsr_en   = wr_ctl && !din[MODE_FLAG];
    bsr_mask = DW'(1) << din[BIT_IW:1];
    bsr_val  = din[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTL_RESET;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    dir.a_in  = ctrl_q[DIR_A];
    dir.cu_in = ctrl_q[DIR_CU];
    dir.b_in  = ctrl_q[DIR_B];
    dir.cl_in = ctrl_q[DIR_CL];
  end

  AST_BSR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_en |=> $stable(ctrl_q)); // R8
endmodule

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int W        = 8,
  parameter bit LATCH_IN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr,
  input  logic         bsr_en,
  input  logic [W-1:0] bsr_mask,
  input  logic         bsr_val,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] pins_out,
  output logic [W-1:0] pins_oe,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] out_q;
  logic [W-1:0] out_d;
  logic         out_en;
  logic [W-1:0] in_view;

  always_comb begin
    out_en = clr || wr_en || (bsr_en && (bsr_mask != '0));
    out_d  = out_q;
    if (clr) begin
      out_d = '0;
    end else if (wr_en) begin
      out_d = wr_data;
    end else if (bsr_en) begin
      out_d = (out_q & ~bsr_mask) | (bsr_mask & {W{bsr_val}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  if (LATCH_IN) begin : g_latched
    logic [W-1:0] in_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q <= '0;
      end else if (in_mode) begin
        in_q <= pins_in;
      end
    end
    assign in_view = in_q;

    AST_INPUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      in_mode |=> (in_q == $past(pins_in))); // R10
  end else begin : g_live
    assign in_view = pins_in;
  end

  always_comb begin
    pins_out = out_q;
    pins_oe  = {W{!in_mode}};
    rd_data  = in_mode ? in_view : out_q;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pins_out == '0)); // R7
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic            rst_i_n;
  logic            rd_act;
  logic            wr_act;
  logic [NSEL-1:0] sel;
  logic [DW-1:0]   ctrl_q;
  dir_t            dir;
  logic            mode_clr;
  logic            bsr_en;
  logic [DW-1:0]   bsr_mask;
  logic            bsr_val;
  logic [DW-1:0]   pa_rd;
  logic [DW-1:0]   pb_rd;
  logic [DW-1:0]   pc_rd;

  ppi_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i_n)
  );

  ppi_bus_decode u_dec (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .rd_act (rd_act),
    .wr_act (wr_act),
    .sel    (sel)
  );

  ppi_ctrl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_ctl   (wr_act && sel[SEL_CTL]),
    .din      (d_in),
    .ctrl_q   (ctrl_q),
    .dir      (dir),
    .mode_clr (mode_clr),
    .bsr_en   (bsr_en),
    .bsr_mask (bsr_mask),
    .bsr_val  (bsr_val)
  );

  ppi_port #(.W(DW), .LATCH_IN(1'b1)) u_pa (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .in_mode  (dir.a_in),
    .wr_en    (wr_act && sel[SEL_A]),
    .wr_data  (d_in),
    .clr      (mode_clr),
    .bsr_en   (1'b0),
    .bsr_mask ('0),
    .bsr_val  (1'b0),
    .pins_in  (pa_in),
    .pins_out (pa_out),
    .pins_oe  (pa_oe),
    .rd_data  (pa_rd)
  );

  ppi_port #(.W(DW), .LATCH_IN(1'b0)) u_pb (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .in_mode  (dir.b_in),
    .wr_en    (wr_act && sel[SEL_B]),
    .wr_data  (d_in),
    .clr      (mode_clr),
    .bsr_en   (1'b0),
    .bsr_mask ('0),
    .bsr_val  (1'b0),
    .pins_in  (pb_in),
    .pins_out (pb_out),
    .pins_oe  (pb_oe),
    .rd_data  (pb_rd)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pc_nib
    localparam int LO = g * NW;
    ppi_port #(.W(NW), .LATCH_IN(1'b0)) u_pc (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .in_mode  ((g == 1) ? dir.cu_in : dir.cl_in),
      .wr_en    (wr_act && sel[SEL_C]),
      .wr_data  (d_in[LO +: NW]),
      .clr      (mode_clr),
      .bsr_en   (bsr_en),
      .bsr_mask (bsr_mask[LO +: NW]),
      .bsr_val  (bsr_val),
      .pins_in  (pc_in[LO +: NW]),
      .pins_out (pc_out[LO +: NW]),
      .pins_oe  (pc_oe[LO +: NW]),
      .rd_data  (pc_rd[LO +: NW])
    );
  end

  always_comb begin
    d_oe  = rd_act;
    d_out = '0;
    if (rd_act) begin
      case (sel_e'(addr))
        SEL_A:   d_out = pa_rd;
        SEL_B:   d_out = pb_rd;
        SEL_C:   d_out = pc_rd;
        default: d_out = {1'b1, ctrl_q[DW-2:0]};
      endcase
    end
  end

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cs_n || (rd_n && wr_n)) |-> !d_oe); // R3
  AST_CONFLICT_NOP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cs_n && !rd_n && !wr_n) |=> ($stable(ctrl_q) && $stable(pa_out) && $stable(pc_out))); // R4
  AST_CTL_MSB_SET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (d_oe && addr == SEL_CTL) |-> d_out[DW-1]); // R5
  AST_A_OE_DIR: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pa_oe != '0) |-> !ctrl_q[DIR_A]); // R6
endmodule

// File: tb/ppi_top_bench.sv
`timescale 1ns/100ps
module ppi_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] d_in, d_out, pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe, pc_in, pc_out, pc_oe;
  logic       d_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] ctrl_m, pa_m, pb_m, pc_m, pa_lat, rd_last;

  always #2.5 clk = ~clk;

  ppi_top u_ppi_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: exp_rd = ctrl_m[4] ? pa_lat : pa_m;
      2'd1: exp_rd = ctrl_m[1] ? pb_in : pb_m;
      2'd2: exp_rd = {ctrl_m[3] ? pc_in[7:4] : pc_m[7:4], ctrl_m[0] ? pc_in[3:0] : pc_m[3:0]};
      default: exp_rd = {1'b1, ctrl_m[6:0]};
    endcase
  endfunction

  function automatic string rd_tag(input logic [1:0] a);
    if (a == 2'd3) return "R5";
    if (a == 2'd0 && ctrl_m[4]) return "R10";
    if (a == 2'd1 && ctrl_m[1]) return "R10";
    if (a == 2'd2 && (ctrl_m[3] || ctrl_m[0])) return "R10";
    return "R9";
  endfunction

  task automatic step(input logic cs, input logic rd, input logic wr,
                      input logic [1:0] a, input logic [7:0] d);
    logic rd_ok, wr_ok;
    @(negedge clk);
    cs_n = cs; rd_n = rd; wr_n = wr; addr = a; d_in = d;
    pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
    #1;
    rd_ok = !cs && !rd && wr;
    wr_ok = !cs && rd && !wr;
    if (!cs && !rd && !wr) chk("R4 bus", {7'd0, d_oe}, 8'd0);
    else if (!rd_ok) chk("R3 bus", {7'd0, d_oe}, 8'd0);
    else begin
      chk("R2 oe", {7'd0, d_oe}, 8'd1);
      rd_last = d_out;
      chk(rd_tag(a), d_out, exp_rd(a));
    end
    chk("R11 pa_out", pa_out, pa_m);
    chk("R11 pb_out", pb_out, pb_m);
    chk("R11 pc_out", pc_out, pc_m);
    chk("R6 pa_oe", pa_oe, {8{~ctrl_m[4]}});
    chk("R6 pb_oe", pb_oe, {8{~ctrl_m[1]}});
    chk("R6 pc_oe", pc_oe, {{4{~ctrl_m[3]}}, {4{~ctrl_m[0]}}});
    @(posedge clk);
    if (ctrl_m[4]) pa_lat = pa_in;
    if (wr_ok) begin
      case (a)
        2'd0: pa_m = d;
        2'd1: pb_m = d;
        2'd2: pc_m = d;
        default: begin
          if (d[7]) begin
            ctrl_m = d; pa_m = 8'h00; pb_m = 8'h00; pc_m = 8'h00;
          end else begin
            pc_m[d[3:1]] = d[0];
          end
        end
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [1:0] a);
    step(1'b0, 1'b0, 1'b1, a, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 2'd0; d_in = 8'h00;
    pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'h00;
    ctrl_m = 8'h9B; pa_m = 8'h00; pb_m = 8'h00; pc_m = 8'h00; pa_lat = 8'h00; rd_last = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(2'd3);
    chk("R1 ctrl", rd_last, 8'h9B);
    chk("R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    chk("R1 latches", pa_out | pb_out | pc_out, 8'h00);

    // R6 all outputs, R9 latch readback
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3); wr(2'd2, 8'h0F);
    rd(2'd0); chk("R9 A", rd_last, 8'h5A);
    rd(2'd1); chk("R9 B", rd_last, 8'hC3);
    rd(2'd2); chk("R9 C", rd_last, 8'h0F);

    // R8 set/clear on the top and bottom bits
    wr(2'd3, 8'h0F);
    wr(2'd3, 8'h00);
    rd(2'd2); chk("R8 pc", rd_last, 8'h8E);
    rd(2'd3); chk("R8 ctrl kept", rd_last, 8'h80);

    // R4 conflicting strobes change nothing
    step(1'b0, 1'b0, 1'b0, 2'd0, 8'hFF);
    step(1'b0, 1'b0, 1'b0, 2'd3, 8'h9B);
    rd(2'd0); chk("R4 A kept", rd_last, 8'h5A);
    rd(2'd3); chk("R4 ctrl kept", rd_last, 8'h80);

    // R3 deselected write ignored
    step(1'b1, 1'b1, 1'b0, 2'd1, 8'h11);
    rd(2'd1); chk("R3 B kept", rd_last, 8'hC3);

    // R12 mode fields stored but no effect, R7 clear
    wr(2'd3, 8'hE4);
    rd(2'd3); chk("R12 ctrl", rd_last, 8'hE4);
    chk("R7 cleared", pa_out | pb_out | pc_out, 8'h00);
    chk("R12 oe", pa_oe & pb_oe & pc_oe, 8'hFF);
    wr(2'd0, 8'hA5); rd(2'd0); chk("R12 A", rd_last, 8'hA5);

    // R10 mixed nibbles and port A capture
    wr(2'd3, 8'h99);
    repeat (4) rd(2'd0);
    repeat (4) rd(2'd2);
    repeat (4) rd(2'd1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      logic [1:0] a;
      logic [7:0] d;
      op = 4'($urandom);
      a  = 2'($urandom);
      d  = 8'($urandom);
      case (op)
        4'd0: step(1'b1, 1'($urandom), 1'($urandom), a, d);
        4'd1: step(1'b0, 1'b0, 1'b0, a, d);
        4'd2: step(1'b0, 1'b1, 1'b1, a, d);
        4'd3, 4'd4, 4'd5, 4'd6: wr(a, d);
        4'd7: wr(2'd3, {1'b0, d[6:0]});
        default: rd(a);
      endcase
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule